// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt lines and hands each of up to four CPUs its own interrupt output. Every source has to get through two independent gates before it reaches a CPU. The first gate is a single global enable per source. The second is a mask kept separately for each CPU. A routing field per source also names the CPUs that may take it. Software never does read-modify-write on bitmaps. It changes an enable or a mask by writing the bare source index to a set register or a clear register.

The register port is shared by all CPUs, and each access carries the number of the CPU that issues it. A per-CPU window at offset 0x800 always acts on the issuing CPU. Inside that window the CPU masks or unmasks sources and reads its acknowledge register. The acknowledge read returns the lowest-numbered source that can be delivered to that CPU, or 1023 when none can.

The lowest `N_PCPU` sources are private to each CPU, so every CPU has its own line for each of them. Sources 0 and 1 carry the doorbell summaries (inter-processor and message-signalled) on these private lines. All higher sources are shared lines that every CPU sees.

Top module: `dual_gate_intc`

## Requirements
- R1: After reset all global enables are clear, all per-CPU masks are set and all routing fields are zero. As a result `irq_o` is low and every CPU's acknowledge read returns 1023.
- R2: Writing the 32-bit value i to offset 0x030 sets the global enable of source i. Writing i to offset 0x034 clears it. A written value of `N_SRC` or more changes nothing.
- R3: Writing index i to window offset 0x848 masks source i for the CPU named on `bus_cpu_i`. Writing i to 0x84C unmasks it. The masks of all other CPUs are left unchanged.
- R4: The routing word of source i is at 0x100 + 4*i, and its bit n lets CPU n receive the source. A read returns these `N_CPU` bits with all upper bits zero. Upper bits of a write are dropped.
- R5: A read of offset 0x000 returns `N_SRC` in bits [11:2]. All other bits of that read are zero.
- R6: A source is deliverable to CPU n only when four conditions all hold. Its line for CPU n is high, it is globally enabled, it is unmasked for CPU n, and routing bit n is set.
- R7: A read of window offset 0x844 returns, in bits [9:0], the lowest-index source deliverable to the issuing CPU. It returns 1023 when no source is deliverable. Bits [31:10] read zero.
- R8: For a source i below `N_PCPU`, CPU n sees it only through line `pcpu_lvl_i[n*N_PCPU+i]`. For a source i at `N_PCPU` or above, every CPU sees it through `glob_lvl_i[i-N_PCPU]`.
- R9: Sources are level-sensitive. An acknowledge read does not clear anything, and a source stops being deliverable once its line drops.
- R10: Read data and `bus_rvalid_o` appear in the cycle after a read strobe, and `bus_rvalid_o` is low in every other cycle. Reads of undefined offsets return zero. Writes to undefined or misaligned offsets are ignored.
- R11: `irq_o[n]` is registered. It is high exactly one cycle after some source became deliverable to CPU n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_cpu_i | input | CPU_W | Number of the CPU issuing the access |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 32 | Read data |
| pcpu_lvl_i | input | N_CPU*N_PCPU | Private source lines, one group per CPU |
| glob_lvl_i | input | N_SRC-N_PCPU | Shared source lines |
| irq_o | output | N_CPU | Interrupt request, one per CPU |

## Verification
The bench walks every source on every CPU. It checks that a private line raises only its own CPU and that a shared line raises all of them; a design that mixed up the line grouping would raise the wrong CPU or return a wrong ID. It then removes the gates one at a time: the global enable, the mask of the issuing CPU, the mask of a different CPU, and a routing bit. A design that merged the two gate levels, or applied a window write to the wrong CPU, would deliver a source it should block or block one it should deliver. Further tests stack many pending lines and drop them in order. This exposes a priority encoder that favours the wrong end, and an acknowledge that clears state. Finally the bench writes out-of-range indices such as 40 and 69, misaligned addresses and undefined offsets. These catch an index that is truncated to a valid one, and a decoder that is too loose.

// File: rtl/dgi_pkg.sv
`timescale 1ns/1ps
package dgi_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int ID_W   = 10;

    // global register page
    localparam logic [ADDR_W-1:0] A_INFO       = 12'h000;
    localparam logic [ADDR_W-1:0] A_EN_SET     = 12'h030;
    localparam logic [ADDR_W-1:0] A_EN_CLR     = 12'h034;
    localparam logic [ADDR_W-1:0] A_ROUTE_BASE = 12'h100;
    // banked per-CPU page
    localparam logic [ADDR_W-1:0] A_WIN_BASE   = 12'h800;
    localparam logic [ADDR_W-1:0] W_ACK        = 12'h044;
    localparam logic [ADDR_W-1:0] W_MASK_SET   = 12'h048;
    localparam logic [ADDR_W-1:0] W_MASK_CLR   = 12'h04C;
    localparam logic [ADDR_W-1:0] A_ACK        = A_WIN_BASE + W_ACK;

    localparam logic [ID_W-1:0] ID_NONE = 10'h3FF;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MASK_SET,
        OP_MASK_CLR,
        OP_ROUTE
    } wr_op_e;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_INFO,
        RD_ROUTE,
        RD_ACK
    } rd_sel_e;
endpackage

// File: rtl/dgi_decode.sv
`timescale 1ns/1ps
// Address and command decode for the register port (purely combinational).
module dgi_decode
    import dgi_pkg::*;
#(
    parameter int N_SRC = 40,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output wr_op_e            wr_op_o,
    output rd_sel_e           rd_sel_o,
    output logic [SRC_W-1:0]  idx_o
);
    localparam logic [DATA_W-1:0] SRC_LIM    = DATA_W'(N_SRC);
    localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(4 * N_SRC);

    logic [ADDR_W-1:0] route_off;
    logic [ADDR_W-1:0] win_off;
    logic              in_route;
    logic              in_win;
    logic              data_ok;

    always_comb begin
        route_off = addr_i - A_ROUTE_BASE;
        win_off   = addr_i - A_WIN_BASE;
        in_route  = (route_off < ROUTE_SPAN) && (route_off[1:0] == 2'b00);
        in_win    = addr_i >= A_WIN_BASE;
        data_ok   = wdata_i < SRC_LIM;

        idx_o = in_route ? route_off[SRC_W+1:2] : wdata_i[SRC_W-1:0];

        wr_op_o = OP_IDLE;
        if (req_i && we_i) begin
            if (addr_i == A_EN_SET && data_ok)
                wr_op_o = OP_EN_SET;
            else if (addr_i == A_EN_CLR && data_ok)
                wr_op_o = OP_EN_CLR;
            else if (in_win && win_off == W_MASK_SET && data_ok)
                wr_op_o = OP_MASK_SET;
            else if (in_win && win_off == W_MASK_CLR && data_ok)
                wr_op_o = OP_MASK_CLR;
            else if (in_route)
                wr_op_o = OP_ROUTE;
        end

        rd_sel_o = RD_ZERO;
        if (req_i && !we_i) begin
            if (addr_i == A_INFO)
                rd_sel_o = RD_INFO;
            else if (in_route)
                rd_sel_o = RD_ROUTE;
            else if (in_win && win_off == W_ACK)
                rd_sel_o = RD_ACK;
        end
    end
endmodule

// File: rtl/dgi_gate_state.sv
`timescale 1ns/1ps
// Global enables, per-CPU masks and routing fields.
module dgi_gate_state
    import dgi_pkg::*;
#(
    parameter int N_SRC = 40,
    parameter int N_CPU = 4,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  wr_op_e                       wr_op_i,
    input  logic [SRC_W-1:0]             idx_i,
    input  logic [CPU_W-1:0]             cpu_i,
    input  logic [N_CPU-1:0]             route_i,
    output logic [N_SRC-1:0]             en_o,
    output logic [N_CPU-1:0][N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0][N_CPU-1:0]  route_o
);
    typedef struct packed {
        logic [N_SRC-1:0]            en;
        logic [N_CPU-1:0][N_SRC-1:0] mask;
        logic [N_SRC-1:0][N_CPU-1:0] route;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        unique case (wr_op_i)
            OP_EN_SET:   gate_d.en[idx_i]          = 1'b1;
            OP_EN_CLR:   gate_d.en[idx_i]          = 1'b0;
            OP_MASK_SET: gate_d.mask[cpu_i][idx_i] = 1'b1;
            OP_MASK_CLR: gate_d.mask[cpu_i][idx_i] = 1'b0;
            OP_ROUTE:    gate_d.route[idx_i]       = route_i;
            default:     ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q.en    <= '0;
            gate_q.mask  <= '1;
            gate_q.route <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign en_o    = gate_q.en;
    assign mask_o  = gate_q.mask;
    assign route_o = gate_q.route;
endmodule

// File: rtl/dgi_pick.sv
`timescale 1ns/1ps
// Per-CPU qualification and lowest-index-wins selection.
module dgi_pick
    import dgi_pkg::*;
#(
    parameter int N_SRC = 40,
    parameter int N_CPU = 4
) (
    input  logic [N_CPU-1:0][N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0]            en_i,
    input  logic [N_CPU-1:0][N_SRC-1:0] mask_i,
    input  logic [N_SRC-1:0][N_CPU-1:0] route_i,
    output logic [N_CPU-1:0]            hit_o,
    output logic [N_CPU-1:0][ID_W-1:0]  id_o
);
    for (genvar n = 0; n < N_CPU; n++) begin : g_cpu
        logic [N_SRC-1:0] elig;
        logic [ID_W-1:0]  id_c;

        always_comb begin
            for (int i = 0; i < N_SRC; i++)
                elig[i] = pend_i[n][i] & en_i[i] & ~mask_i[n][i] & route_i[i][n];
            id_c = ID_NONE;
            for (int i = N_SRC - 1; i >= 0; i--)
                if (elig[i]) id_c = ID_W'(i);
        end

        assign hit_o[n] = |elig;
        assign id_o[n]  = id_c;
    end
endmodule

// File: rtl/dual_gate_intc.sv
`timescale 1ns/1ps
// Two-level multi-CPU interrupt controller, top level.
module dual_gate_intc
    import dgi_pkg::*;
#(
    parameter int N_SRC  = 40,
    parameter int N_CPU  = 4,
    parameter int N_PCPU = 29,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int N_GLB = N_SRC - N_PCPU
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      bus_req_i,
    input  logic                      bus_we_i,
    input  logic [CPU_W-1:0]          bus_cpu_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    output logic                      bus_rvalid_o,
    output logic [DATA_W-1:0]         bus_rdata_o,
    input  logic [N_CPU*N_PCPU-1:0]   pcpu_lvl_i,
    input  logic [N_GLB-1:0]          glob_lvl_i,
    output logic [N_CPU-1:0]          irq_o
);
    wr_op_e                      dec_op;
    rd_sel_e                     dec_rd;
    logic [SRC_W-1:0]            dec_idx;
    logic [N_SRC-1:0]            gate_en;
    logic [N_CPU-1:0][N_SRC-1:0] gate_mask;
    logic [N_SRC-1:0][N_CPU-1:0] gate_route;
    logic [N_CPU-1:0][N_SRC-1:0] pend;
    logic [N_CPU-1:0]            hit;
    logic [N_CPU-1:0][ID_W-1:0]  pick_id;

    // private lines below N_PCPU, shared lines above
    for (genvar n = 0; n < N_CPU; n++) begin : g_pend_cpu
        for (genvar i = 0; i < N_SRC; i++) begin : g_pend_src
            if (i < N_PCPU) begin : g_private
                assign pend[n][i] = pcpu_lvl_i[n*N_PCPU + i];
            end else begin : g_shared
                assign pend[n][i] = glob_lvl_i[i - N_PCPU];
            end
        end
    end

    dgi_decode #(.N_SRC(N_SRC)) i_decode (
        .req_i   (bus_req_i),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .wr_op_o (dec_op),
        .rd_sel_o(dec_rd),
        .idx_o   (dec_idx)
    );

    dgi_gate_state #(.N_SRC(N_SRC), .N_CPU(N_CPU)) i_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_op_i(dec_op),
        .idx_i  (dec_idx),
        .cpu_i  (bus_cpu_i),
        .route_i(bus_wdata_i[N_CPU-1:0]),
        .en_o   (gate_en),
        .mask_o (gate_mask),
        .route_o(gate_route)
    );

    dgi_pick #(.N_SRC(N_SRC), .N_CPU(N_CPU)) i_pick (
        .pend_i (pend),
        .en_i   (gate_en),
        .mask_i (gate_mask),
        .route_i(gate_route),
        .hit_o  (hit),
        .id_o   (pick_id)
    );

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic [N_CPU-1:0]  irq;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.rvalid = bus_req_i && !bus_we_i;
        out_d.irq    = hit;
        unique case (dec_rd)
            RD_INFO:  out_d.rdata = {20'b0, ID_W'(N_SRC), 2'b00};
            RD_ROUTE: out_d.rdata = DATA_W'(gate_route[dec_idx]);
            RD_ACK:   out_d.rdata = hit[bus_cpu_i] ? {22'b0, pick_id[bus_cpu_i]}
                                                   : {22'b0, ID_NONE};
            default:  out_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign bus_rvalid_o = out_q.rvalid;
    assign bus_rdata_o  = out_q.rdata;
    assign irq_o        = out_q.irq;
endmodule

// File: rtl/dgi_checker.sv
`timescale 1ns/1ps
module dgi_checker
    import dgi_pkg::*;
#(
    parameter int N_SRC = 40,
    parameter int N_CPU = 4,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        bus_req_i,
    input logic                        bus_we_i,
    input logic [CPU_W-1:0]            bus_cpu_i,
    input logic [ADDR_W-1:0]           bus_addr_i,
    input logic [DATA_W-1:0]           bus_wdata_i,
    input logic                        bus_rvalid_o,
    input logic [DATA_W-1:0]           bus_rdata_o,
    input logic [N_CPU-1:0]            irq_o,
    input logic [N_SRC-1:0]            en_i,
    input logic [N_CPU-1:0][N_SRC-1:0] mask_i,
    input logic [N_SRC-1:0][N_CPU-1:0] route_i
);
    localparam logic [DATA_W-1:0] LIM32 = DATA_W'(N_SRC);
    localparam logic [ID_W-1:0]   LIMID = ID_W'(N_SRC);

    logic [N_CPU-1:0] rcol;
    always_comb begin
        rcol = '0;
        for (int i = 0; i < N_SRC; i++) rcol = rcol | route_i[i];
    end

    a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (en_i == '0 && route_i == '0 && (&mask_i)));

    a_r2_set_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && bus_we_i && bus_addr_i == A_EN_SET && bus_wdata_i < LIM32)
        |=> en_i[$past(bus_wdata_i[SRC_W-1:0])]);

    a_r2_clear_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && bus_we_i && bus_addr_i == A_EN_CLR && bus_wdata_i < LIM32)
        |=> !en_i[$past(bus_wdata_i[SRC_W-1:0])]);

    a_r3_mask_own_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && bus_we_i && bus_addr_i == (A_WIN_BASE + W_MASK_SET) && bus_wdata_i < LIM32)
        |=> mask_i[$past(bus_cpu_i)][$past(bus_wdata_i[SRC_W-1:0])]);

    a_r7_ack_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && !bus_we_i && bus_addr_i == A_ACK)
        |=> (bus_rdata_o[DATA_W-1:ID_W] == '0 &&
             (bus_rdata_o[ID_W-1:0] < LIMID || bus_rdata_o[ID_W-1:0] == ID_NONE)));

    a_r10_rvalid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && !bus_we_i) |=> bus_rvalid_o);

    a_r10_rvalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_req_i && !bus_we_i) |=> !bus_rvalid_o);

    for (genvar n = 0; n < N_CPU; n++) begin : g_cpu
        a_r6_irq_needs_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[n] |-> $past(rcol[n] && (|en_i) && !(&mask_i[n])));
    end
endmodule

bind dual_gate_intc dgi_checker #(.N_SRC(N_SRC), .N_CPU(N_CPU)) i_dgi_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_cpu_i   (bus_cpu_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rvalid_o(bus_rvalid_o),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .en_i        (gate_en),
    .mask_i      (gate_mask),
    .route_i     (gate_route)
);

// File: tb/test_dual_gate_intc.sv
`timescale 1ns/1ps
module test_dual_gate_intc;
    localparam int NS = 40;
    localparam int NC = 4;
    localparam int NP = 29;
    localparam int NG = NS - NP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0, we = 1'b0;
    logic [1:0]        cpu = '0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic              rvalid;
    logic [31:0]       rdata;
    logic [NC*NP-1:0]  pl = '0;
    logic [NG-1:0]     gl = '0;
    logic [NC-1:0]     irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of the register state and lines
    bit m_en [NS];
    bit m_mask [NC][NS];
    bit m_rt [NS][NC];
    bit m_pl [NC][NP];
    bit m_gl [NG];

    always #2.5 clk = ~clk;

    dual_gate_intc #(.N_SRC(NS), .N_CPU(NC), .N_PCPU(NP)) i_dual_gate_intc (
        .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
        .bus_cpu_i(cpu), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
        .pcpu_lvl_i(pl), .glob_lvl_i(gl), .irq_o(irq)
    );

    function automatic int exp_id(int c);
        for (int i = 0; i < NS; i++) begin
            bit p = (i < NP) ? m_pl[c][i] : m_gl[i-NP];
            if (p && m_en[i] && !m_mask[c][i] && m_rt[i][c]) return i;
        end
        return 1023;
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] e = '0;
        for (int c = 0; c < NC; c++) e[c] = (exp_id(c) != 1023);
        return e;
    endfunction

    task automatic check(string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic wr(int c, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; cpu = 2'(c); addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(int c, logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; cpu = 2'(c); addr = a;
        @(negedge clk);
        req = 1'b0;
        check("R10 rvalid after read", 32'(rvalid), 32'd1);
        d = rdata;
    endtask

    task automatic set_en(int i);
        wr(0, 12'h030, 32'(i));
        if (i < NS) m_en[i] = 1;
    endtask
    task automatic clr_en(int i);
        wr(0, 12'h034, 32'(i));
        if (i < NS) m_en[i] = 0;
    endtask
    task automatic mask(int c, int i);
        wr(c, 12'h848, 32'(i));
        m_mask[c][i] = 1;
    endtask
    task automatic unmask(int c, int i);
        wr(c, 12'h84C, 32'(i));
        m_mask[c][i] = 0;
    endtask
    task automatic route(int i, logic [31:0] v);
        wr(0, 12'h100 + 12'(4*i), v);
        for (int c = 0; c < NC; c++) m_rt[i][c] = v[c];
    endtask

    task automatic drive_lines();
        @(negedge clk);
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < NP; i++) pl[c*NP+i] = m_pl[c][i];
        for (int g = 0; g < NG; g++) gl[g] = m_gl[g];
    endtask

    // one edge for irq_o to follow, then each CPU's acknowledge
    task automatic settle(string tag);
        logic [31:0] got;
        @(negedge clk);
        check({tag, " R6 R11 irq_o"}, 32'(irq), 32'(exp_irq()));
        for (int c = 0; c < NC; c++) begin
            rd(c, 12'h844, got);
            check({tag, " R7 ack"}, got, 32'(exp_id(c)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        for (int i = 0; i < NS; i++) begin
            m_en[i] = 0;
            for (int c = 0; c < NC; c++) begin m_mask[c][i] = 1; m_rt[i][c] = 0; end
        end
        for (int c = 0; c < NC; c++) for (int i = 0; i < NP; i++) m_pl[c][i] = 0;
        for (int g = 0; g < NG; g++) m_gl[g] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5 / R4: reset state
        @(negedge clk);
        check("R1 irq_o after reset", 32'(irq), 32'd0);
        check("R10 rvalid idle", 32'(rvalid), 32'd0);
        rd(0, 12'h000, got);
        check("R5 source count", got, 32'(NS) << 2);
        for (int i = 0; i < NS; i++) begin
            rd(0, 12'h100 + 12'(4*i), got);
            check("R1 R4 route reset", got, 32'd0);
        end
        settle("R1 reset");

        // R1: masks set after reset block an enabled, routed source
        set_en(35); route(35, 32'hF);
        m_gl[35-NP] = 1; drive_lines();
        settle("R1 masks set");
        m_gl[35-NP] = 0; drive_lines();

        // open every gate for every source
        for (int i = 0; i < NS; i++) begin set_en(i); route(i, 32'hF); end
        for (int c = 0; c < NC; c++) for (int i = 0; i < NS; i++) unmask(c, i);
        settle("R6 all open idle");

        // R8: every line on every CPU
        for (int i = 0; i < NS; i++) begin
            if (i < NP) begin
                for (int c = 0; c < NC; c++) begin
                    m_pl[c][i] = 1; drive_lines();
                    settle("R8 private line");
                    m_pl[c][i] = 0;
                end
            end else begin
                m_gl[i-NP] = 1; drive_lines();
                settle("R8 shared line");
                m_gl[i-NP] = 0;
            end
        end
        drive_lines();

        // R11: irq_o follows one edge later
        m_gl[30-NP] = 1; drive_lines();
        check("R11 irq_o before edge", 32'(irq), 32'd0);
        @(negedge clk);
        check("R11 irq_o after edge", 32'(irq), 32'hF);

        // R3 / R4 / R2 / R6: removing gates one at a time
        m_gl[30-NP] = 0;
        m_gl[33-NP] = 1; m_pl[2][7] = 1; drive_lines();
        settle("R6 base");
        mask(1, 33); settle("R3 cpu1 masks 33");
        unmask(1, 33);
        mask(0, 7); settle("R3 other cpu mask no effect");
        mask(2, 7); settle("R3 own cpu mask");
        unmask(0, 7); unmask(2, 7);
        route(33, 32'hB); settle("R4 route bit2 cleared");
        route(7, 32'h0); settle("R6 route zero");
        route(7, 32'hF); route(33, 32'hF);
        clr_en(33); settle("R2 disable shared");
        clr_en(7); settle("R2 disable private");
        set_en(7); set_en(33); settle("R2 re-enable");

        // R7 / R9: priority with many pending, drained in order
        m_gl[33-NP] = 0; m_pl[2][7] = 0;
        for (int g = 0; g < NG; g++) m_gl[g] = 1;
        m_pl[0][10] = 1; m_pl[0][20] = 1; m_pl[3][28] = 1; m_pl[1][0] = 1;
        drive_lines();
        settle("R7 stacked");
        rd(0, 12'h844, got);
        check("R9 second ack unchanged", got, 32'd10);
        for (int i = 0; i < NS; i++) begin
            bit any = 0;
            if (i < NP) begin
                for (int c = 0; c < NC; c++) if (m_pl[c][i]) begin any = 1; m_pl[c][i] = 0; end
            end else if (m_gl[i-NP]) begin
                any = 1; m_gl[i-NP] = 0;
            end
            if (any) begin drive_lines(); settle("R9 R7 drop lowest"); end
        end

        // R2 / R10: out-of-range and undefined accesses
        clr_en(5);
        m_pl[1][5] = 1; drive_lines();
        settle("R2 source 5 disabled");
        wr(0, 12'h030, 32'd69);
        wr(0, 12'h030, 32'h0000_0405);
        wr(0, 12'h030, 32'(NS));
        wr(0, 12'h038, 32'd5);
        wr(1, 12'h850, 32'd5);
        wr(1, 12'h84C + 12'h400, 32'd5);
        settle("R2 R10 ignored writes");
        set_en(5); settle("R2 enable 5");
        wr(1, 12'h848, 32'd69);
        settle("R3 out-of-range mask ignored");
        rd(0, 12'h010, got); check("R10 undefined read", got, 32'd0);
        rd(0, 12'h848, got); check("R10 write-only read", got, 32'd0);
        rd(0, 12'h100 + 12'(4*NS), got); check("R10 past routing words", got, 32'd0);
        wr(0, 12'h100 + 12'(4*NS), 32'hF);
        wr(0, 12'h102, 32'h0);
        rd(0, 12'h100, got); check("R10 misaligned write ignored", got, 32'hF);
        route(6, 32'hFFFF_FFF5);
        rd(0, 12'h118, got); check("R4 upper route bits dropped", got, 32'h5);
        @(negedge clk);
        check("R10 rvalid low without read", 32'(rvalid), 32'd0);
        settle("R4 R6 final");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule